// File: doc/BRIEF.md
# Keyboard Character Register Interface

This block holds the two 16-bit registers that a processor uses to collect keystrokes: a status register and a data register. On the bus side, each register has its own read strobe and its own write strobe, plus one shared write-data word. A bus access always completes in the cycle it is issued.

On the device side, a sequencer accepts 8-bit characters from a character source through a valid/acknowledge handshake. For each character it runs the same sequence:

- It stores the character in the data register.
- It raises the ready flag in bit 15 of the status register.
- It waits for the processor to read the data register.
- It lowers the ready flag again.
- It releases the source for the next character.

The sequencer never writes a register directly. It raises a per-register write request and waits for the matching grant. A bus write to the same register always wins, and the grant is held back until a cycle with no bus write to that register.

Top module: `kbc_top`

## Requirements
- R1: While `rst` is high at a clock edge, both registers become 0x0000, and `src_ack` and `src_done` become 0. The sequencer then waits idle for a character.
- R2: A bus write strobe to either register loads `bus_wdata` into that register at the next clock edge. This holds even if the device side is requesting a write to the same register.
- R3: A character accepted from the source is written to the data register zero-extended: the character in bits 7:0 and zeros in bits 15:8.
- R4: Once the data register write is granted, the status register is written with bit 15 set and bits 14:0 keeping their current value.
- R5: The ready bit (status bit 15) stays set until a bus read strobe on the data register is seen. Status register reads have no effect on it.
- R6: After a data register read strobe, the status register is written with bit 15 cleared and bits 14:0 keeping their current value.
- R7: `src_done` is high for exactly one cycle: the cycle right after the data register read strobe that ends a character's wait.
- R8: `src_ack` rises the cycle after an idle sequencer sees `src_valid`, and stays high until the sequence has finished. While `src_ack` is high, no new character is taken and `src_char` has no effect on the data register.
- R9: If a bus write and a device write request hit the same register in the same cycle, the bus value is stored. The device value is stored in a later cycle with no bus write to that register, and the request stays raised until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_stat_rd | input | 1 | Bus read strobe, status register |
| bus_stat_wr | input | 1 | Bus write strobe, status register |
| bus_data_rd | input | 1 | Bus read strobe, data register |
| bus_data_wr | input | 1 | Bus write strobe, data register |
| bus_wdata | input | 16 | Bus write data |
| stat_q | output | 16 | Status register contents (bit 15 = ready) |
| data_q | output | 16 | Data register contents |
| src_valid | input | 1 | Character source has a character |
| src_char | input | 8 | Character from the source |
| src_ack | output | 1 | Character taken; held until its sequence has finished |
| src_done | output | 1 | One-cycle pulse: the character has been consumed by the bus |

## Verification
On every cycle, the assertions check the following rules:

- A bus write always lands in the register at the next edge.
- A grant only follows a request made in a cycle with no bus write to that register.
- A pending status request stays raised until it is granted.
- The ready bit cannot fall while the sequencer is waiting and neither side is writing.
- The consumed pulse lasts a single cycle and only appears while a character is held.

Some behaviour can only be shown by the bench's scenarios:

- The zero-extended character value.
- Preservation of status bits 14:0 across the set and the clear.
- Status reads being ignored.
- Characters offered while one is held being dropped.
- The value stored after a write collision is resolved.

// File: rtl/kbc_pkg.sv
package kbc_pkg;

    localparam int KBC_REG_W  = 16;
    localparam int KBC_CHAR_W = 8;

    typedef enum logic [2:0] {
        SQ_IDLE   = 3'd0,
        SQ_WDATA  = 3'd1,
        SQ_SETRDY = 3'd2,
        SQ_WAITRD = 3'd3,
        SQ_CLRRDY = 3'd4,
        SQ_FINISH = 3'd5
    } seq_state_t;

    function automatic logic seq_holds_char(seq_state_t s);
        return s != SQ_IDLE;
    endfunction

    function automatic logic seq_wants_stat(seq_state_t s);
        return (s == SQ_SETRDY) || (s == SQ_CLRRDY);
    endfunction

endpackage

// File: rtl/kbc_reg.sv
module kbc_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bus_wr,
    input  logic [W-1:0] bus_wdata,
    input  logic         dev_req,
    input  logic [W-1:0] dev_wdata,
    output logic [W-1:0] q,
    output logic         dev_gnt
);

    // The bus always wins. A device write lands only in a cycle with no
    // bus write, and the grant is returned one cycle after that write.
    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= '0;
            dev_gnt <= 1'b0;
        end else if (bus_wr) begin
            q       <= bus_wdata;
            dev_gnt <= 1'b0;
        end else if (dev_req && !dev_gnt) begin
            q       <= dev_wdata;
            dev_gnt <= 1'b1;
        end else begin
            dev_gnt <= 1'b0;
        end
    end

endmodule

// File: rtl/kbc_seq.sv
module kbc_seq
    import kbc_pkg::*;
#(
    parameter int REG_W  = 16,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              src_valid,
    input  logic [CHAR_W-1:0] src_char,
    input  logic              bus_data_rd,
    input  logic [REG_W-1:0]  stat_q,
    input  logic              data_gnt,
    input  logic              stat_gnt,
    output logic              data_req,
    output logic [REG_W-1:0]  data_wval,
    output logic              stat_req,
    output logic [REG_W-1:0]  stat_wval,
    output logic              src_ack,
    output logic              src_done,
    output seq_state_t        state
);

    localparam int RDY_BIT = REG_W - 1;
    localparam int PAD_W   = REG_W - CHAR_W;

    seq_state_t        nxt;
    logic [CHAR_W-1:0] held_char;

    always_comb begin
        nxt = state;
        unique case (state)
            SQ_IDLE:   if (src_valid)   nxt = SQ_WDATA;
            SQ_WDATA:  if (data_gnt)    nxt = SQ_SETRDY;
            SQ_SETRDY: if (stat_gnt)    nxt = SQ_WAITRD;
            SQ_WAITRD: if (bus_data_rd) nxt = SQ_CLRRDY;
            SQ_CLRRDY: if (stat_gnt)    nxt = SQ_FINISH;
            SQ_FINISH:                  nxt = SQ_IDLE;
            default:                    nxt = SQ_IDLE;
        endcase
    end

    // Write values for both registers. The status value keeps bits 14:0
    // as they are now and only changes the ready bit.
    always_comb begin
        data_req  = (state == SQ_WDATA);
        data_wval = {{PAD_W{1'b0}}, held_char};
        stat_req  = seq_wants_stat(state);
        stat_wval = stat_q;
        stat_wval[RDY_BIT] = (state == SQ_SETRDY);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            held_char <= '0;
            src_ack   <= 1'b0;
            src_done  <= 1'b0;
        end else begin
            state    <= nxt;
            src_done <= (state == SQ_WAITRD) && bus_data_rd;
            if (state == SQ_IDLE && src_valid) begin
                held_char <= src_char;
                src_ack   <= 1'b1;
            end else if (state == SQ_FINISH) begin
                src_ack   <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/kbc_top.sv
module kbc_top
    import kbc_pkg::*;
#(
    parameter int REG_W  = KBC_REG_W,
    parameter int CHAR_W = KBC_CHAR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_stat_rd,
    input  logic              bus_stat_wr,
    input  logic              bus_data_rd,
    input  logic              bus_data_wr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  stat_q,
    output logic [REG_W-1:0]  data_q,
    input  logic              src_valid,
    input  logic [CHAR_W-1:0] src_char,
    output logic              src_ack,
    output logic              src_done
);

    logic             data_req, data_gnt;
    logic             stat_req, stat_gnt;
    logic [REG_W-1:0] data_wval, stat_wval;
    seq_state_t       seq_state;
    logic             stat_rd_unused;

    // Read strobes carry no side effect in the registers themselves.
    assign stat_rd_unused = bus_stat_rd;

    kbc_reg #(.W(REG_W)) u_stat (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_stat_wr),
        .bus_wdata (bus_wdata),
        .dev_req   (stat_req),
        .dev_wdata (stat_wval),
        .q         (stat_q),
        .dev_gnt   (stat_gnt)
    );

    kbc_reg #(.W(REG_W)) u_data (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_data_wr),
        .bus_wdata (bus_wdata),
        .dev_req   (data_req),
        .dev_wdata (data_wval),
        .q         (data_q),
        .dev_gnt   (data_gnt)
    );

    kbc_seq #(.REG_W(REG_W), .CHAR_W(CHAR_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .src_valid   (src_valid),
        .src_char    (src_char),
        .bus_data_rd (bus_data_rd),
        .stat_q      (stat_q),
        .data_gnt    (data_gnt),
        .stat_gnt    (stat_gnt),
        .data_req    (data_req),
        .data_wval   (data_wval),
        .stat_req    (stat_req),
        .stat_wval   (stat_wval),
        .src_ack     (src_ack),
        .src_done    (src_done),
        .state       (seq_state)
    );

endmodule

// File: rtl/kbc_checker.sv
module kbc_checker #(
    parameter int REG_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_stat_wr,
    input logic             bus_data_wr,
    input logic [REG_W-1:0] bus_wdata,
    input logic [REG_W-1:0] stat_q,
    input logic [REG_W-1:0] data_q,
    input logic             stat_req,
    input logic             stat_gnt,
    input logic             data_req,
    input logic             data_gnt,
    input logic             src_ack,
    input logic             src_done
);

    p_reset_clears_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (stat_q == '0 && data_q == '0 && !src_ack && !src_done));

    p_bus_stat_wins_r2: assert property (@(posedge clk) disable iff (rst)
        bus_stat_wr |=> stat_q == $past(bus_wdata));

    p_bus_data_wins_r2: assert property (@(posedge clk) disable iff (rst)
        bus_data_wr |=> data_q == $past(bus_wdata));

    p_stat_grant_after_free_r9: assert property (@(posedge clk) disable iff (rst)
        stat_gnt |-> ($past(stat_req) && !$past(bus_stat_wr)));

    p_data_grant_after_free_r9: assert property (@(posedge clk) disable iff (rst)
        data_gnt |-> ($past(data_req) && !$past(bus_data_wr)));

    p_stat_req_held_r9: assert property (@(posedge clk) disable iff (rst)
        (stat_req && !stat_gnt) |=> stat_req);

    p_ready_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (stat_q[REG_W-1] && src_ack && !stat_req && !bus_stat_wr) |=> stat_q[REG_W-1]);

    p_done_one_cycle_r7: assert property (@(posedge clk) disable iff (rst)
        src_done |=> !src_done);

    p_done_while_held_r8: assert property (@(posedge clk) disable iff (rst)
        src_done |-> src_ack);

endmodule

bind kbc_top kbc_checker #(.REG_W(REG_W)) u_chk (.*);

// File: tb/kbc_top_test.sv
module kbc_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_stat_rd = 1'b0, bus_stat_wr = 1'b0;
    logic        bus_data_rd = 1'b0, bus_data_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] stat_q, data_q;
    logic        src_valid = 1'b0;
    logic [7:0]  src_char = '0;
    logic        src_ack, src_done;

    int checks = 0;
    int errors = 0;
    bit ended  = 0;

    always #5 clk = ~clk;

    kbc_top uut (.*);

    function automatic logic [15:0] exp_char(logic [7:0] c);
        return {8'h00, c};
    endfunction

    function automatic logic [15:0] exp_rdy(logic [15:0] v, logic b);
        return {b, v[14:0]};
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wait_ready(output bit ok);
        ok = 0;
        for (int i = 0; i < 20; i++) begin
            tick();
            if (stat_q[15]) begin ok = 1; break; end
        end
    endtask

    task automatic wait_ack_low(output bit ok);
        ok = 0;
        for (int i = 0; i < 20; i++) begin
            if (!src_ack) begin ok = 1; break; end
            tick();
        end
    endtask

    task automatic bus_wr_stat(logic [15:0] v);
        bus_stat_wr = 1; bus_wdata = v; tick(); bus_stat_wr = 0;
    endtask

    // Offer a character, expect it registered and ready raised.
    task automatic offer(logic [7:0] c, logic [15:0] stat_before);
        bit ok;
        src_valid = 1; src_char = c;
        tick();
        chk("R8 ack rises", {15'd0, src_ack}, 16'd1);
        src_valid = 0; src_char = ~c;
        wait_ready(ok);
        chk("R4 ready seen", {15'd0, ok}, 16'd1);
        chk("R3 data zext", data_q, exp_char(c));
        chk("R4 status set", stat_q, exp_rdy(stat_before, 1'b1));
        tick(); tick();
    endtask

    // Read the data register and expect the pulse, the clear and the release.
    task automatic consume(logic [15:0] stat_before);
        bit ok;
        bus_data_rd = 1; tick(); bus_data_rd = 0;
        chk("R7 done high", {15'd0, src_done}, 16'd1);
        tick();
        chk("R7 done one cycle", {15'd0, src_done}, 16'd0);
        wait_ack_low(ok);
        chk("R8 ack released", {15'd0, ok}, 16'd1);
        chk("R6 status cleared", stat_q, exp_rdy(stat_before, 1'b0));
    endtask

    initial begin
        logic [15:0] sv;
        logic [7:0]  c;
        void'($urandom(32'h5eed_0042));
        repeat (3) tick();
        rst = 0;
        tick();
        chk("R1 status reset", stat_q, 16'h0000);
        chk("R1 data reset", data_q, 16'h0000);
        chk("R1 ack reset", {15'd0, src_ack}, 16'd0);
        chk("R1 done reset", {15'd0, src_done}, 16'd0);

        // R2: plain bus writes.
        bus_data_wr = 1; bus_wdata = 16'hbeef; tick(); bus_data_wr = 0;
        chk("R2 data bus write", data_q, 16'hbeef);
        bus_wr_stat(16'h1234);
        chk("R2 status bus write", stat_q, 16'h1234);

        // Directed: full sequence, status reads ignored.
        offer(8'hff, 16'h1234);
        for (int i = 0; i < 4; i++) begin
            bus_stat_rd = 1; tick();
        end
        bus_stat_rd = 0;
        chk("R5 stat reads ignored", stat_q, 16'h9234);
        chk("R5 no done on stat read", {15'd0, src_done}, 16'd0);
        // R8: character offered while one is held is dropped.
        src_valid = 1; src_char = 8'h5a;
        repeat (3) tick();
        chk("R8 held char kept", data_q, exp_char(8'hff));
        src_valid = 0;
        consume(16'h1234);
        chk("R8 no capture after drop", data_q, exp_char(8'hff));
        chk("R8 ack stays low", {15'd0, src_ack}, 16'd0);

        // Directed: bus write collides with the ready-set request.
        begin
            bit ok;
            src_valid = 1; src_char = 8'h41;
            tick(); src_valid = 0;
            for (int i = 0; i < 20; i++) begin
                if (data_q == exp_char(8'h41)) break;
                tick();
            end
            bus_stat_wr = 1; bus_wdata = 16'h0456;
            for (int i = 0; i < 5; i++) begin
                tick();
                chk("R9 bus wins collision", stat_q, 16'h0456);
            end
            bus_stat_wr = 0;
            wait_ready(ok);
            chk("R9 device write later", stat_q, 16'h8456);
            tick(); tick();
            consume(16'h0456);
        end

        // Random characters, status bits and delays.
        sv = 16'h0456;
        for (int n = 0; n < 24; n++) begin
            if ($urandom_range(0, 1) == 1) begin
                sv = 16'($urandom) & 16'h7fff;
                bus_wr_stat(sv);
                chk("R2 random status write", stat_q, sv);
            end
            c = 8'($urandom);
            offer(c, sv);
            for (int d = 0; d < int'($urandom_range(0, 6)); d++) begin
                bus_stat_rd = 1'($urandom);
                tick();
            end
            bus_stat_rd = 0;
            chk("R5 ready still set", stat_q, exp_rdy(sv, 1'b1));
            consume(sv);
        end

        // Reset mid-sequence.
        src_valid = 1; src_char = 8'h33; tick(); src_valid = 0;
        repeat (4) tick();
        rst = 1; tick(); rst = 0; tick();
        chk("R1 status after reset", stat_q, 16'h0000);
        chk("R1 data after reset", data_q, 16'h0000);
        chk("R1 ack after reset", {15'd0, src_ack}, 16'd0);

        if (!ended) begin
            ended = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule